// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind the serial slave engine of a 2048-byte non-volatile memory model. During a write transaction it gathers the data bytes into a 16-entry staging buffer. Each entry carries a valid bit. The buffer is tied to one 128-byte-aligned... more exactly, to one 16-byte page, and the page is fixed by the word address that the engine loads. When the engine reports STOP, the valid entries are copied into the external array through a single write port. This happens inside one internal write cycle of fixed length, and `busy` is held high for that whole cycle.

The block also applies the hardware write-protect rule. The protect level is latched when the engine strobes it, which happens just before the first data byte of the transaction. If that level is high, the block refuses the bytes of the transaction and the STOP commits nothing. A repeated START, as used to turn an address write into a random read, drops the staged bytes. A STOP that follows only an address load, with no data bytes, starts no write cycle. The engine reads `ackOk` to decide whether to acknowledge the byte it is currently handling.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy` is 0, `ackOk` is 1 and `memWrEn` is 0.
- R2: A STOP writes only the buffered bytes to the array. Each byte goes to address {page, entry index}, and the other bytes of the page keep their contents. Entry k is driven on the write port in busy cycle k, counting from 0.
- R3: Each accepted data byte advances only address bits 3:0, and it wraps from 15 back to 0. Bits 10:4, which hold the page, are taken from the loaded address and never change.
- R4: A 17th or later byte lands on an entry that is already filled and overwrites it. Each location is written at most once per commit.
- R5: `busy` rises on the first clock edge after an accepted STOP and stays high for exactly WRITE_CYCLES clock cycles.
- R6: A STOP with no buffered byte produces no busy cycle and no array write.
- R7: A repeated-START strobe discards all buffered bytes, so a STOP that follows it commits nothing.
- R8: If the protect level is high when it is sampled before the first data byte, `ackOk` drops to 0 for the rest of the transaction. The data bytes are then dropped, the STOP writes nothing, and `ackOk` returns to 1 after the STOP.
- R9: A protect sample taken after a data byte has already been buffered has no effect. `ackOk` stays 1 and the bytes are committed.
- R10: While `busy` is 1, `ackOk` is 0 and every strobe is ignored: an address load, a data byte, a STOP or a repeated START.
- R11: A protect sample at high level in the same cycle as the first data byte rejects that byte and the rest of the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrLoad | input | 1 | Strobe: word address received; starts a new transaction |
| addrIn | input | 11 | Word address; bits 10:4 page, bits 3:0 entry |
| dataStrobe | input | 1 | Strobe: one data byte received |
| dataIn | input | 8 | Data byte that goes with `dataStrobe` |
| stopStrobe | input | 1 | Strobe: STOP condition seen |
| restartStrobe | input | 1 | Strobe: repeated START seen |
| protSample | input | 1 | Strobe: take the protect level now |
| protLevel | input | 1 | Write-protect level (1 = protected) |
| ackOk | output | 1 | The current byte may be acknowledged |
| busy | output | 1 | Internal write cycle in progress |
| memWrEn | output | 1 | Array write enable |
| memWrAddr | output | 11 | Array write address |
| memWrData | output | 8 | Array write data |

## Verification
Two functions can meet in one clock cycle. The protect sample decides whether the transaction is rejected, and the first data byte tries to enter the buffer. The bench asserts both strobes on the same clock edge. It expects `ackOk` to be low in the next cycle, and it expects the following STOP to produce no busy cycle and leave the array untouched.

The bench also sends address, data and STOP strobes while a commit is draining. It then checks that a later lone STOP starts no cycle and that the array matches the reference model. Random transactions add early and late protect samples, page wraps and restarts. Each of them is judged against a bench-side copy of the array.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned PWB_PAGE_BYTES = 16;
  localparam int unsigned PWB_ADDR_W     = 11;
  localparam int unsigned PWB_DATA_W     = 8;

  // Commands from the control to the datapath
  typedef struct packed {
    logic setAddr;    // load page and entry pointer
    logic storeByte;  // write dataIn at the pointer, then advance it
    logic clearMask;  // drop all valid bits
    logic drainEn;    // present one entry on the array port
  } pwb_cmd_t;
endpackage

// File: rtl/pwb_dpath.sv
module pwb_dpath
  import pwb_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = PWB_PAGE_BYTES,
  parameter int unsigned ADDR_W     = PWB_ADDR_W,
  parameter int unsigned DATA_W     = PWB_DATA_W,
  localparam int unsigned IDX_W     = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W    = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwb_cmd_t          cmd,
  input  logic [IDX_W-1:0]  drainIdx,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              anyValid,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);

  logic [PAGE_W-1:0]     pageQ;
  logic [IDX_W-1:0]      ptrQ;
  logic [PAGE_BYTES-1:0] validQ;
  logic [DATA_W-1:0]     bufQ [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] hitVec;

  // Decode of the entry that the pointer selects
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_hit
    assign hitVec[g] = cmd.storeByte && (ptrQ == IDX_W'(g));
  end

  // Page and pointer; only the low pointer bits move (R3)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ <= '0;
      ptrQ  <= '0;
    end else if (cmd.setAddr) begin
      pageQ <= addrIn[ADDR_W-1:IDX_W];
      ptrQ  <= addrIn[IDX_W-1:0];
    end else if (cmd.storeByte) begin
      ptrQ  <= ptrQ + IDX_W'(1);
    end
  end

  // Staging entries and valid mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) bufQ[i] <= '0;
    end else begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (hitVec[i]) bufQ[i] <= dataIn;
      end
      if (cmd.clearMask) validQ <= '0;
      else               validQ <= validQ | hitVec;
    end
  end

  assign anyValid  = |validQ;
  assign memWrEn   = cmd.drainEn && validQ[drainIdx];
  assign memWrAddr = {pageQ, drainIdx};
  assign memWrData = bufQ[drainIdx];

  p_page_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.storeByte |=> $stable(pageQ));

  p_mask_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.drainEn && !cmd.clearMask) |=> $stable(validQ));

endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 500000,
  parameter int unsigned PAGE_BYTES   = PWB_PAGE_BYTES,
  localparam int unsigned IDX_W       = $clog2(PAGE_BYTES),
  localparam int unsigned TIMER_W     = $clog2(WRITE_CYCLES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrLoad,
  input  logic             dataStrobe,
  input  logic             stopStrobe,
  input  logic             restartStrobe,
  input  logic             protSample,
  input  logic             protLevel,
  input  logic             anyValid,
  output pwb_cmd_t         cmd,
  output logic [IDX_W-1:0] drainIdx,
  output logic             busy,
  output logic             ackOk
);

  logic               busyQ;
  logic               rejQ;
  logic [TIMER_W-1:0] timerQ;
  logic               idle;
  logic               protHit;
  logic               rejEff;
  logic               commitGo;
  logic               lastTick;
  logic               otherEvt;

  assign idle     = !busyQ;
  // Protect counts only before the first buffered byte (R8, R9, R11)
  assign protHit  = idle && protSample && protLevel && !anyValid;
  assign rejEff   = rejQ || protHit;
  assign otherEvt = addrLoad || stopStrobe || restartStrobe;
  assign commitGo = idle && stopStrobe && anyValid && !rejEff;
  assign lastTick = busyQ && (timerQ == TIMER_W'(WRITE_CYCLES - 1));

  always_comb begin
    cmd.setAddr   = idle && addrLoad;
    cmd.storeByte = idle && dataStrobe && !rejEff && !otherEvt;
    cmd.clearMask = (idle && (addrLoad || restartStrobe || (stopStrobe && !commitGo)))
                    || lastTick;
    cmd.drainEn   = busyQ && (timerQ < TIMER_W'(PAGE_BYTES));
  end

  assign drainIdx = timerQ[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      timerQ <= '0;
    end else if (commitGo) begin
      busyQ  <= 1'b1;
      timerQ <= '0;
    end else if (lastTick) begin
      busyQ  <= 1'b0;
      timerQ <= '0;
    end else if (busyQ) begin
      timerQ <= timerQ + TIMER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rejQ <= 1'b0;
    else if (idle && otherEvt) rejQ <= 1'b0;
    else if (protHit)          rejQ <= 1'b1;
  end

  assign busy  = busyQ;
  assign ackOk = idle && !rejQ;

  p_busy_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(stopStrobe));

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && (timerQ != TIMER_W'(WRITE_CYCLES - 1))) |=> busyQ);

  p_empty_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (idle && stopStrobe && !anyValid) |=> !busyQ);

  p_reject_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    rejQ |-> !cmd.storeByte);

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
  import pwb_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 500000,
  parameter int unsigned PAGE_BYTES   = PWB_PAGE_BYTES,
  parameter int unsigned ADDR_W       = PWB_ADDR_W,
  parameter int unsigned DATA_W       = PWB_DATA_W,
  localparam int unsigned IDX_W       = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              dataStrobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              stopStrobe,
  input  logic              restartStrobe,
  input  logic              protSample,
  input  logic              protLevel,
  output logic              ackOk,
  output logic              busy,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);

  pwb_cmd_t         cmd;
  logic [IDX_W-1:0] drainIdx;
  logic             anyValid;

  pwb_ctrl #(
    .WRITE_CYCLES(WRITE_CYCLES),
    .PAGE_BYTES  (PAGE_BYTES)
  ) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .addrLoad     (addrLoad),
    .dataStrobe   (dataStrobe),
    .stopStrobe   (stopStrobe),
    .restartStrobe(restartStrobe),
    .protSample   (protSample),
    .protLevel    (protLevel),
    .anyValid     (anyValid),
    .cmd          (cmd),
    .drainIdx     (drainIdx),
    .busy         (busy),
    .ackOk        (ackOk)
  );

  pwb_dpath #(
    .PAGE_BYTES(PAGE_BYTES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .drainIdx (drainIdx),
    .addrIn   (addrIn),
    .dataIn   (dataIn),
    .anyValid (anyValid),
    .memWrEn  (memWrEn),
    .memWrAddr(memWrAddr),
    .memWrData(memWrData)
  );

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memWrEn);

endmodule

// File: tb/test_page_write_buffer.sv
module test_page_write_buffer;
  localparam int WC = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrLoad = 1'b0;
  logic [10:0] addrIn = '0;
  logic        dataStrobe = 1'b0;
  logic [7:0]  dataIn = '0;
  logic        stopStrobe = 1'b0;
  logic        restartStrobe = 1'b0;
  logic        protSample = 1'b0;
  logic        protLevel = 1'b0;
  logic        ackOk, busy, memWrEn;
  logic [10:0] memWrAddr;
  logic [7:0]  memWrData;

  always #5 clk = ~clk;

  page_write_buffer #(.WRITE_CYCLES(WC)) i_page_write_buffer (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .addrIn(addrIn),
    .dataStrobe(dataStrobe), .dataIn(dataIn), .stopStrobe(stopStrobe),
    .restartStrobe(restartStrobe), .protSample(protSample), .protLevel(protLevel),
    .ackOk(ackOk), .busy(busy), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData)
  );

  int errors = 0;
  int checks = 0;
  int wrCount = 0;
  logic [7:0] dutMem [2048];
  logic [7:0] expMem [2048];

  // Reference model of the staging state
  logic [7:0]  mBuf [16];
  logic [15:0] mValid = '0;
  logic [6:0]  mPage = '0;
  logic [3:0]  mPtr = '0;
  bit          mRej = 1'b0;

  initial for (int i = 0; i < 2048; i++) begin dutMem[i] = 8'hFF; expMem[i] = 8'hFF; end

  // Array image built from the write port
  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      dutMem[memWrAddr] = memWrData;
      wrCount++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void mAddr(input logic [10:0] a);
    mPage = a[10:4]; mPtr = a[3:0]; mValid = '0; mRej = 1'b0;
  endfunction
  function automatic void mProt(input logic l);
    if (l && mValid == 16'd0) mRej = 1'b1;
  endfunction
  function automatic void mData(input logic [7:0] d);
    if (!mRej) begin mBuf[mPtr] = d; mValid[mPtr] = 1'b1; mPtr = mPtr + 4'd1; end
  endfunction
  function automatic int mStop();
    int n = 0;
    if (!mRej)
      for (int k = 0; k < 16; k++)
        if (mValid[k]) begin expMem[{mPage, 4'(k)}] = mBuf[k]; n++; end
    mValid = '0; mRej = 1'b0;
    return n;
  endfunction

  task automatic doAddr(input logic [10:0] a);
    addrIn = a; addrLoad = 1'b1; @(negedge clk); addrLoad = 1'b0; mAddr(a);
  endtask
  task automatic doData(input logic [7:0] d);
    dataIn = d; dataStrobe = 1'b1; @(negedge clk); dataStrobe = 1'b0; mData(d);
  endtask
  task automatic doProt(input logic l);
    protLevel = l; protSample = 1'b1; @(negedge clk); protSample = 1'b0; protLevel = 1'b0; mProt(l);
  endtask
  task automatic doRestart();
    restartStrobe = 1'b1; @(negedge clk); restartStrobe = 1'b0; mValid = '0; mRej = 1'b0;
  endtask
  task automatic doStop(input string req);
    int n, len;
    logic first;
    n = mStop();
    wrCount = 0;
    stopStrobe = 1'b1; @(negedge clk); stopStrobe = 1'b0;
    first = busy;
    len = 0;
    while (busy) begin len++; @(negedge clk); end
    check(len == ((n > 0) ? WC : 0), req, "busy cycles", len, (n > 0) ? WC : 0);
    check(wrCount == n, req, "array writes", wrCount, n);
    if (n > 0) check(first == 1'b1, "R5", "busy in first cycle after STOP", int'(first), 1);
  endtask
  task automatic memCompare(input string req);
    int mism = 0;
    for (int i = 0; i < 2048; i++) if (dutMem[i] !== expMem[i]) mism++;
    check(mism == 0, req, "array mismatches", mism, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1", "busy", int'(busy), 0);
    check(ackOk == 1'b1, "R1", "ackOk", int'(ackOk), 1);
    check(memWrEn == 1'b0, "R1", "memWrEn", int'(memWrEn), 0);

    // R2: one byte, rest of page untouched
    doAddr(11'h123); doData(8'hA5);
    check(ackOk == 1'b1, "R2", "ackOk while loading", int'(ackOk), 1);
    doStop("R2"); memCompare("R2");

    // R3: wrap inside the page
    doAddr(11'h7FD);
    for (int i = 0; i < 5; i++) doData(8'(8'h30 + i));
    doStop("R3"); memCompare("R3");

    // R4: 18 bytes overwrite entries 0 and 1
    doAddr(11'h230);
    for (int i = 0; i < 18; i++) doData(8'(i + 1));
    doStop("R4"); memCompare("R4");
    check(dutMem[11'h230] == 8'd17, "R4", "entry 0 overwritten", int'(dutMem[11'h230]), 17);

    // R6: dummy address write
    doAddr(11'h400); doStop("R6");

    // R7: repeated START discards the buffer
    doAddr(11'h500); doData(8'h01); doData(8'h02); doData(8'h03);
    doRestart(); doStop("R7"); memCompare("R7");

    // R8: protect high before the first byte
    doAddr(11'h600); doProt(1'b1);
    check(ackOk == 1'b0, "R8", "ackOk after protect", int'(ackOk), 0);
    doData(8'h44); doData(8'h45);
    doStop("R8");
    check(ackOk == 1'b1, "R8", "ackOk after STOP", int'(ackOk), 1);
    memCompare("R8");

    // R9: late protect sample is ignored
    doAddr(11'h610); doData(8'h51); doProt(1'b1);
    check(ackOk == 1'b1, "R9", "ackOk after late protect", int'(ackOk), 1);
    doData(8'h52); doStop("R9"); memCompare("R9");

    // R10: strobes during busy are ignored
    doAddr(11'h620); doData(8'h11);
    begin
      int n, len;
      n = mStop();
      wrCount = 0;
      stopStrobe = 1'b1; @(negedge clk); stopStrobe = 1'b0;
      check(ackOk == 1'b0, "R10", "ackOk while busy", int'(ackOk), 0);
      addrIn = 11'h700; addrLoad = 1'b1; @(negedge clk); addrLoad = 1'b0;
      dataIn = 8'h99; dataStrobe = 1'b1; @(negedge clk); dataStrobe = 1'b0;
      restartStrobe = 1'b1; @(negedge clk); restartStrobe = 1'b0;
      stopStrobe = 1'b1; @(negedge clk); stopStrobe = 1'b0;
      len = 4;
      while (busy) begin len++; @(negedge clk); end
      check(len == WC, "R10", "busy not extended", len, WC);
      check(wrCount == n, "R10", "writes of first commit", wrCount, n);
    end
    doStop("R10"); memCompare("R10");

    // R11: protect and first byte in the same cycle
    doAddr(11'h630);
    protSample = 1'b1; protLevel = 1'b1; dataStrobe = 1'b1; dataIn = 8'h77;
    @(negedge clk);
    protSample = 1'b0; protLevel = 1'b0; dataStrobe = 1'b0;
    mProt(1'b1); mData(8'h77);
    check(ackOk == 1'b0, "R11", "ackOk after joint strobe", int'(ackOk), 0);
    doStop("R11"); memCompare("R11");

    // Random transactions (R2, R3, R4, R7, R8, R9)
    for (int t = 0; t < 40; t++) begin
      int n;
      doAddr(11'($urandom_range(0, 2047)));
      doProt(($urandom_range(0, 5) == 0) ? 1'b1 : 1'b0);
      n = $urandom_range(1, 20);
      for (int b = 0; b < n; b++) begin
        doData(8'($urandom));
        if (b == 0 && $urandom_range(0, 3) == 0) doProt(1'b1);
      end
      if ($urandom_range(0, 7) == 0) doRestart();
      doStop("R2"); memCompare("R4");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule